// File: doc/BRIEF.md
# Hash Message Padder and Block Former

This unit sits in front of a 512-bit block compression engine for a Merkle-Damgard style hash. It accepts a message one byte per handshake, gathers the bytes into 64-byte blocks and hands each full block downstream as soon as its last byte arrives. When the producer marks the end of the message, the unit closes it with the standard tail. The byte 0x80 goes right after the last data byte, then zero bytes follow. The message length in bits goes into the final eight bytes as a big-endian 64-bit number. If that tail does not fit into the current block, a second block is produced.

A byte counter runs across every block of one message and restarts for the next message. A flag travels with the last block of each message, so the engine knows when its chaining value is the finished digest. The producer is held off while padding blocks are formed and while any block waits to be taken. A message with no data bytes is closed by a single beat that carries the end marker and the empty marker.

Top module: `msg_pad_blocker`

## Requirements
- R1: After reset, blk_valid and blk_final are 0 and in_ready is 1.
- R2: Block byte k (counting from 0 in arrival order) sits at blk_data[511-8k -: 8]. A block filled by its 64th data byte is presented with blk_final 0 right after the clock edge that accepts that byte.
- R3: While blk_valid is 1 and blk_ready is 0, blk_valid, blk_data and blk_final hold their values, and in_ready is 0 while blk_valid is 1.
- R4: In the block that closes a message, the byte right after the last data byte is 0x80, and every byte from there up to the length field is 0x00.
- R5: The last eight bytes of the final block hold the message length in bits (data bytes times 8) as a big-endian 64-bit value, most significant byte first, counting the bytes of every block of the message.
- R6: If the message leaves 0 to 55 data bytes in its last block, one padded block with the 0x80 byte and the length field is emitted, marked final. It is presented after the second clock edge following the acceptance of the closing beat.
- R7: If the message leaves 56 to 63 data bytes in its last block, two blocks follow. The first holds those bytes, 0x80 and zeros, with blk_final 0. The second is all zero except the length field, with blk_final 1.
- R8: A message of zero bytes (one beat with in_last and in_empty both 1) produces one block: 0x80 in byte 0, zeros, and a length of 0, marked final.
- R9: The byte count restarts at zero for each new message, so the length field of a message does not depend on earlier messages.
- R10: From the edge that accepts a beat with in_last 1 until the final block of that message has been taken, in_ready is 0.
- R11: blk_final is 1 only on the last block of a message. Every earlier block carries 0.
- R12: A message whose length is a non-zero multiple of 64 bytes gets its data blocks (non-final), then one extra block holding 0x80, zeros and the length field, marked final.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input beat offered |
| in_byte | input | 8 | Message byte |
| in_last | input | 1 | Beat closes the message |
| in_empty | input | 1 | Beat carries no data byte (used with in_last for an empty message) |
| in_ready | output | 1 | Beat accepted when high together with in_valid |
| blk_valid | output | 1 | Output block presented |
| blk_data | output | 512 | Block, first byte in the top eight bits |
| blk_final | output | 1 | Block is the last one of the message |
| blk_ready | input | 1 | Downstream takes the block |

## Verification
A full data block is due one edge after its 64th byte is accepted. A padded closing block is due two edges after the closing beat, because the pad state is entered on the first edge and the block register loads on the second. The second tail block of a long remainder comes one edge after the first one is taken. The directed tasks sample on the falling edge. They check blk_valid and in_ready at those exact falling edges after the accepting edge, and they hold blk_ready low for several cycles to check that a waiting block stays frozen. Whole block contents are compared against blocks built in the bench from the message length and a byte pattern, with remainders of 3, 55, 56, 63 and 0 bytes, multiples of the block size, and a long message followed by a short one.

// File: rtl/mpb_pkg.sv
package mpb_pkg;

  typedef enum logic [1:0] {
    ST_FILL = 2'd0,
    ST_PAD  = 2'd1,
    ST_TAIL = 2'd2
  } mpb_state_e;

  // what the block former builds this cycle
  typedef enum logic [1:0] {
    FORM_DATA = 2'd0,  // full block of message bytes
    FORM_PAD  = 2'd1,  // remainder, 0x80, zeros, optional length
    FORM_TAIL = 2'd2   // zeros plus length
  } form_e;

endpackage

// File: rtl/mpb_len_counter.sv
module mpb_len_counter #(
  parameter int LEN_W = 64,
  localparam int CNT_W = LEN_W - 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [LEN_W-1:0] bit_len
);

  logic [CNT_W-1:0] byte_cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      byte_cnt <= '0;
    end else if (inc) begin
      byte_cnt <= byte_cnt + CNT_W'(1);
    end
  end

  // bits = bytes * 8
  assign bit_len = {byte_cnt, 3'b000};

endmodule

// File: rtl/mpb_byte_store.sv
module mpb_byte_store #(
  parameter int NBYTES = 64,
  localparam int IDX_W = $clog2(NBYTES),
  localparam int BLK_W = NBYTES * 8
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_byte,
  output logic [BLK_W-1:0] stored
);

  logic [7:0] mem [NBYTES];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_idx] <= wr_byte;
    end
  end

  for (genvar i = 0; i < NBYTES; i++) begin : g_flat
    assign stored[BLK_W-1-8*i -: 8] = mem[i];
  end

endmodule

// File: rtl/mpb_block_former.sv
module mpb_block_former
  import mpb_pkg::*;
#(
  parameter int NBYTES = 64,
  parameter int LEN_W  = 64,
  localparam int IDX_W   = $clog2(NBYTES),
  localparam int BLK_W   = NBYTES * 8,
  localparam int LEN_POS = NBYTES - LEN_W / 8
) (
  input  form_e            mode,
  input  logic [IDX_W-1:0] fill,
  input  logic             with_len,
  input  logic [BLK_W-1:0] stored,
  input  logic [7:0]       in_byte,
  input  logic [LEN_W-1:0] bit_len,
  output logic [BLK_W-1:0] blk
);

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    localparam logic [IDX_W-1:0] POS = IDX_W'(i);
    localparam bit IS_LAST = (i == NBYTES - 1);
    localparam bit IN_LEN  = (i >= LEN_POS);

    logic [7:0] st_b;
    logic [7:0] len_b;
    logic [7:0] ob;

    assign st_b = stored[BLK_W-1-8*i -: 8];

    if (IN_LEN) begin : g_len
      assign len_b = bit_len[LEN_W-1-8*(i-LEN_POS) -: 8];
    end else begin : g_nolen
      assign len_b = 8'h00;
    end

    always_comb begin
      ob = 8'h00;
      case (mode)
        FORM_DATA: begin
          ob = IS_LAST ? in_byte : st_b;
        end
        FORM_PAD: begin
          if (fill > POS) begin
            ob = st_b;
          end else if (fill == POS) begin
            ob = 8'h80;
          end else begin
            ob = 8'h00;
          end
          if (with_len && IN_LEN) begin
            ob = len_b;
          end
        end
        FORM_TAIL: begin
          ob = IN_LEN ? len_b : 8'h00;
        end
        default: ob = 8'h00;
      endcase
    end

    assign blk[BLK_W-1-8*i -: 8] = ob;
  end

endmodule

// File: rtl/msg_pad_blocker.sv
module msg_pad_blocker
  import mpb_pkg::*;
#(
  parameter int BLK_BYTES = 64,
  parameter int LEN_W     = 64,
  localparam int BLK_W    = BLK_BYTES * 8,
  localparam int IDX_W    = $clog2(BLK_BYTES),
  localparam int LAST_FIT = BLK_BYTES - LEN_W / 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  input  logic             in_last,
  input  logic             in_empty,
  output logic             in_ready,
  output logic             blk_valid,
  output logic [BLK_W-1:0] blk_data,
  output logic             blk_final,
  input  logic             blk_ready
);

  mpb_state_e       state;
  logic [IDX_W-1:0] fill;
  logic             accept, is_data, blk_full;
  logic             pad_go, tail_go, one_pad, load, final_now;
  form_e            mode;
  logic [BLK_W-1:0] stored, formed;
  logic [LEN_W-1:0] bit_len;

  assign in_ready  = (state == ST_FILL) && !blk_valid;
  assign accept    = in_valid && in_ready;
  assign is_data   = accept && !in_empty;
  assign blk_full  = is_data && (fill == IDX_W'(BLK_BYTES - 1));
  assign pad_go    = (state == ST_PAD) && !blk_valid;
  assign tail_go   = (state == ST_TAIL) && !blk_valid;
  assign one_pad   = fill < IDX_W'(LAST_FIT);
  assign load      = blk_full || pad_go || tail_go;
  assign final_now = (pad_go && one_pad) || tail_go;

  always_comb begin
    if (blk_full) begin
      mode = FORM_DATA;
    end else if (state == ST_TAIL) begin
      mode = FORM_TAIL;
    end else begin
      mode = FORM_PAD;
    end
  end

  mpb_byte_store #(.NBYTES(BLK_BYTES)) u_store (
    .clk     (clk),
    .wr_en   (is_data),
    .wr_idx  (fill),
    .wr_byte (in_byte),
    .stored  (stored)
  );

  mpb_len_counter #(.LEN_W(LEN_W)) u_len (
    .clk     (clk),
    .rst     (rst),
    .clr     (final_now),
    .inc     (is_data),
    .bit_len (bit_len)
  );

  mpb_block_former #(.NBYTES(BLK_BYTES), .LEN_W(LEN_W)) u_form (
    .mode     (mode),
    .fill     (fill),
    .with_len (one_pad),
    .stored   (stored),
    .in_byte  (in_byte),
    .bit_len  (bit_len),
    .blk      (formed)
  );

  // fill index and sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_FILL;
      fill  <= '0;
    end else begin
      if (is_data) begin
        fill <= blk_full ? '0 : fill + IDX_W'(1);
      end else if (pad_go) begin
        fill <= '0;
      end
      case (state)
        ST_FILL: if (accept && in_last) state <= ST_PAD;
        ST_PAD:  if (pad_go) state <= one_pad ? ST_FILL : ST_TAIL;
        ST_TAIL: if (tail_go) state <= ST_FILL;
        default: state <= ST_FILL;
      endcase
    end
  end

  // registered block output
  always_ff @(posedge clk) begin
    if (rst) begin
      blk_valid <= 1'b0;
      blk_final <= 1'b0;
      blk_data  <= '0;
    end else if (load) begin
      blk_valid <= 1'b1;
      blk_final <= final_now;
      blk_data  <= formed;
    end else if (blk_ready) begin
      blk_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/mpb_checker.sv
module mpb_checker #(
  parameter int BLK_W = 512
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_last,
  input logic             blk_valid,
  input logic [BLK_W-1:0] blk_data,
  input logic             blk_final,
  input logic             blk_ready
);

  p_no_accept_r3: assert property (@(posedge clk) disable iff (rst)
    blk_valid |-> !in_ready);

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (blk_valid && !blk_ready) |=> (blk_valid && $stable(blk_data) && $stable(blk_final)));

  p_len_bits_r5: assert property (@(posedge clk) disable iff (rst)
    (blk_valid && blk_final) |-> (blk_data[2:0] == 3'b000));

  p_pad_busy_r10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_last) |=> !in_ready);

  p_gap_after_final_r11: assert property (@(posedge clk) disable iff (rst)
    (blk_valid && blk_final && blk_ready) |=> !blk_valid);

endmodule

bind msg_pad_blocker mpb_checker #(.BLK_W(BLK_BYTES * 8)) u_mpb_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_last   (in_last),
  .blk_valid (blk_valid),
  .blk_data  (blk_data),
  .blk_final (blk_final),
  .blk_ready (blk_ready)
);

// File: tb/tb_msg_pad_blocker.sv
module tb_msg_pad_blocker;
  localparam int NB = 64;
  localparam int BW = NB * 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_last = 1'b0, in_empty = 1'b0, blk_ready = 1'b1;
  logic [7:0] in_byte = 8'h00;
  logic in_ready, blk_valid, blk_final;
  logic [BW-1:0] blk_data;

  always #5 clk = ~clk;

  msg_pad_blocker dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .in_last(in_last), .in_empty(in_empty), .in_ready(in_ready),
    .blk_valid(blk_valid), .blk_data(blk_data), .blk_final(blk_final),
    .blk_ready(blk_ready)
  );

  int checks = 0;
  int fails  = 0;

  logic [BW-1:0] cap_data [0:7];
  logic          cap_final [0:7];
  int            ncap = 0;

  always @(negedge clk) begin
    if (!rst && blk_valid && blk_ready) begin
      if (ncap < 8) begin
        cap_data[ncap]  = blk_data;
        cap_final[ncap] = blk_final;
      end
      ncap = ncap + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [BW-1:0] act, input logic [BW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] dbyte(input int seed, input int i);
    return 8'((seed * 13 + i * 7 + 1) & 255);
  endfunction

  function automatic logic [7:0] ebyte(input int n, input int seed, input int pos);
    int total;
    logic [63:0] bl;
    total = ((n + 9 + NB - 1) / NB) * NB;
    bl = 64'(n) * 64'd8;
    if (pos < n) return dbyte(seed, pos);
    if (pos == n) return 8'h80;
    if (pos >= total - 8) return bl[63 - 8 * (pos - (total - 8)) -: 8];
    return 8'h00;
  endfunction

  function automatic logic [BW-1:0] eblock(input int n, input int seed, input int b);
    logic [BW-1:0] r;
    for (int i = 0; i < NB; i++) r[BW-1-8*i -: 8] = ebyte(n, seed, b * NB + i);
    return r;
  endfunction

  task automatic send_msg(input int n, input int seed);
    if (n == 0) begin
      @(negedge clk);
      in_valid = 1'b1; in_byte = 8'h5A; in_last = 1'b1; in_empty = 1'b1;
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end else begin
      for (int i = 0; i < n; i++) begin
        @(negedge clk);
        in_valid = 1'b1; in_byte = dbyte(seed, i);
        in_last = (i == n - 1); in_empty = 1'b0;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0; in_empty = 1'b0;
  endtask

  task automatic wait_compare(input int n, input int seed, input string req);
    int nblk;
    nblk = (n + 9 + NB - 1) / NB;
    for (int t = 0; t < 400 && ncap < nblk; t++) @(negedge clk);
    repeat (3) @(negedge clk);
    check(ncap == nblk, req, "block count", BW'(ncap), BW'(nblk));
    for (int b = 0; b < nblk && b < 8; b++) begin
      check(cap_data[b] == eblock(n, seed, b), req, "block contents",
            cap_data[b], eblock(n, seed, b));
      check(cap_final[b] == (b == nblk - 1), "R11", "final flag",
            BW'(cap_final[b]), BW'(b == nblk - 1));
    end
  endtask

  task automatic run_msg(input int n, input int seed, input string req);
    ncap = 0;
    send_msg(n, seed);
    wait_compare(n, seed, req);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    check(!blk_valid && !blk_final && in_ready, "R1", "reset outputs",
          BW'({blk_valid, blk_final, in_ready}), BW'(3'b001));
  endtask

  // R2 and R3: full block presented one edge after the 64th byte, frozen while stalled
  task automatic t_stall;
    logic [BW-1:0] held;
    ncap = 0;
    blk_ready = 1'b0;
    send_msg(64, 9);
    check(blk_valid && !blk_final, "R2", "full block timing/flag",
          BW'({blk_valid, blk_final}), BW'(2'b10));
    check(blk_data == eblock(64, 9, 0), "R2", "full block layout",
          blk_data, eblock(64, 9, 0));
    held = blk_data;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(blk_valid && !in_ready && blk_data == held && !blk_final, "R3",
            "stalled block held", blk_data, held);
    end
    @(posedge clk);
    #1 blk_ready = 1'b1;
    wait_compare(64, 9, "R12");
  endtask

  // R6 and R10: padded block due two edges after the closing beat
  task automatic t_timing;
    ncap = 0;
    send_msg(10, 11);
    check(!in_ready && !blk_valid, "R10", "busy right after last beat",
          BW'({in_ready, blk_valid}), BW'(2'b00));
    @(negedge clk);
    check(blk_valid && blk_final && !in_ready, "R6", "padded block latency",
          BW'({blk_valid, blk_final, in_ready}), BW'(3'b110));
    check(blk_data == eblock(10, 11, 0), "R6", "padded block contents",
          blk_data, eblock(10, 11, 0));
    @(negedge clk);
    check(in_ready && !blk_valid, "R10", "ready after final taken",
          BW'({in_ready, blk_valid}), BW'(2'b10));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset;
    run_msg(3, 1, "R4");
    run_msg(55, 2, "R6");
    run_msg(56, 3, "R7");
    run_msg(63, 4, "R7");
    run_msg(0, 5, "R8");
    run_msg(200, 6, "R5");
    run_msg(5, 7, "R9");
    run_msg(128, 8, "R12");
    t_stall;
    t_timing;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule